// File: doc/BRIEF.md
# Branch and Skip Target Selector

This block picks the program counter that follows a flow-control instruction in a small 16-bit-word processor core. Each cycle the decoder may present one instruction class with the current program counter, a relative offset, the status byte, a pointer value, a tested byte with a bit index, a second byte for equality compares, an I/O address and a flag saying whether the instruction after this one occupies two words. One clock later the block returns the chosen program counter, whether flow left the sequential path, and whether the request was an I/O bit test with an address outside the bit-addressable window.

Conditional branches test one status bit, selected by index, for set or clear and move by a short signed word offset. Relative jumps and calls always move by a longer signed offset. Indirect jumps and calls load the pointer. Skips jump over the next instruction, which is one or two words long. The block never writes the status byte; return-address handling and fetch live elsewhere.

Top module: `pc_steer_top`

## Requirements
- R1: While `rstN` is low, `outValid`, `taken` and `illegal` are 0 and `nextPc` is 0.
- R2: Results appear one clock after the request: `outValid` equals `valid` of the previous cycle, and `taken`/`illegal` are 0 when `outValid` is 0.
- R3: Class codes are 0 none, 1 branch-if-set, 2 branch-if-clear, 3 relative jump, 4 relative call, 5 indirect jump, 6 indirect call, 7 skip-if-equal, 8 skip-if-register-bit-set, 9 skip-if-register-bit-clear, 10 skip-if-I/O-bit-set, 11 skip-if-I/O-bit-clear; codes 12 to 15 and every not-taken case give `nextPc` = pc+1 with `taken` 0.
- R4: Classes 1 and 2 test `flags[flagSel]` (bit 0 C, 1 Z, 2 N, 3 V, 4 S, 5 H, 6 T, 7 I) for 1 or 0; when the condition holds, `nextPc` = pc+1+sign-extended `offset[6:0]` (range -64..+63) and `offset[11:7]` has no effect.
- R5: Classes 3 and 4 are always taken with `nextPc` = pc+1+sign-extended `offset[11:0]`.
- R6: Classes 5 and 6 are always taken with `nextPc` = `ptr`.
- R7: Class 7 skips when `testByte` equals `cmpByte`.
- R8: Classes 8 and 9 skip when `testByte[bitIdx]` is 1 or 0 respectively.
- R9: Classes 10 and 11 test `testByte[bitIdx]` only when `ioAddr` is at most 0x1F; above that `illegal` is 1, no skip happens and `nextPc` = pc+1.
- R10: A taken skip gives `nextPc` = pc+3 when `nextTwoWord` is 1 and pc+2 otherwise; `nextTwoWord` has no effect on any other class or on an untaken skip.
- R11: All program counter arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Request present this cycle |
| opClass | input | 4 | Instruction class code |
| pc | input | 16 | Word address of the current instruction |
| offset | input | 12 | Signed relative offset (branches use the low 7 bits) |
| flags | input | 8 | Status byte |
| flagSel | input | 3 | Status bit tested by a branch |
| ptr | input | 16 | Pointer pair value for indirect transfers |
| testByte | input | 8 | Register or I/O byte under test |
| cmpByte | input | 8 | Second register for the equality skip |
| bitIdx | input | 3 | Bit index for bit-test skips |
| ioAddr | input | 6 | I/O address of an I/O bit test |
| nextTwoWord | input | 1 | Following instruction is two words long |
| nextPc | output | 16 | Selected next program counter |
| taken | output | 1 | Flow left the sequential path |
| illegal | output | 1 | I/O bit test addressed outside 0x00..0x1F |
| outValid | output | 1 | Result registers hold a fresh result |

## Verification
The address-window check and the bit-condition decision of an I/O skip land in the same cycle, as do the two-word length of the following instruction and the skip decision. The sweep drives every I/O address from 0 to 63 against every bit index, both bit polarities and both length settings, so bits that would skip meet addresses that forbid it. The outcome is judged on `nextPc`, `taken` and `illegal` together: an out-of-window address must show pc+1 with the illegal mark whatever the bit and the length flag say, and an in-window skip must land two or three words ahead.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;

  typedef enum logic [3:0] {
    OP_NONE  = 4'd0,
    OP_BRSET = 4'd1,
    OP_BRCLR = 4'd2,
    OP_RJMP  = 4'd3,
    OP_RCALL = 4'd4,
    OP_IJMP  = 4'd5,
    OP_ICALL = 4'd6,
    OP_CPSE  = 4'd7,
    OP_SKRS  = 4'd8,
    OP_SKRC  = 4'd9,
    OP_SKIS  = 4'd10,
    OP_SKIC  = 4'd11
  } opClass_e;

  typedef struct packed {
    logic useShort;
    logic useLong;
    logic usePtr;
    logic skipTaken;
    logic badIo;
  } steerStrobe_t;

endpackage

// File: rtl/pc_steer_ctrl.sv
module pc_steer_ctrl
  import pc_steer_pkg::*;
#(
  parameter int IO_ADDR_W    = 6,
  parameter int IO_LOW_LIMIT = 32
) (
  input  logic [3:0]           opClass,
  input  logic [7:0]           flags,
  input  logic [2:0]           flagSel,
  input  logic [7:0]           testByte,
  input  logic [7:0]           cmpByte,
  input  logic [2:0]           bitIdx,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  output steerStrobe_t         strobe
);

  localparam int LIMIT_W = IO_ADDR_W + 1;

  logic flagBit;
  logic dataBit;
  logic ioInWindow;

  assign flagBit    = flags[flagSel];
  assign dataBit    = testByte[bitIdx];
  assign ioInWindow = {1'b0, ioAddr} < LIMIT_W'(IO_LOW_LIMIT);

  always_comb begin
    strobe = '0;
    case (opClass)
      OP_BRSET: strobe.useShort = flagBit;
      OP_BRCLR: strobe.useShort = !flagBit;
      OP_RJMP,
      OP_RCALL: strobe.useLong = 1'b1;
      OP_IJMP,
      OP_ICALL: strobe.usePtr = 1'b1;
      OP_CPSE:  strobe.skipTaken = (testByte == cmpByte);
      OP_SKRS:  strobe.skipTaken = dataBit;
      OP_SKRC:  strobe.skipTaken = !dataBit;
      OP_SKIS: begin
        strobe.badIo     = !ioInWindow;
        strobe.skipTaken = ioInWindow && dataBit;
      end
      OP_SKIC: begin
        strobe.badIo     = !ioInWindow;
        strobe.skipTaken = ioInWindow && !dataBit;
      end
      default: strobe = '0;
    endcase
  end

  always_comb begin
    AST_ONE_TARGET: assert ($onehot0({strobe.useShort, strobe.useLong,
                                      strobe.usePtr, strobe.skipTaken})); // R3
    AST_BAD_IO_NO_SKIP: assert (!(strobe.badIo && strobe.skipTaken)); // R9
  end

endmodule

// File: rtl/pc_steer_path.sv
module pc_steer_path
  import pc_steer_pkg::*;
#(
  parameter int PCW       = 16,
  parameter int BR_OFF_W  = 7,
  parameter int JMP_OFF_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 valid,
  input  logic [PCW-1:0]       pc,
  input  logic [JMP_OFF_W-1:0] offset,
  input  logic [PCW-1:0]       ptr,
  input  logic                 nextTwoWord,
  input  steerStrobe_t         strobe,
  output logic [PCW-1:0]       nextPc,
  output logic                 taken,
  output logic                 illegal,
  output logic                 outValid
);

  localparam int SHORT_PAD = PCW - BR_OFF_W;
  localparam int LONG_PAD  = PCW - JMP_OFF_W;

  logic [PCW-1:0] seqPc;
  logic [PCW-1:0] shortStep;
  logic [PCW-1:0] longStep;
  logic [PCW-1:0] skipStep;
  logic [PCW-1:0] target;
  logic           anyTaken;

  assign seqPc     = pc + PCW'(1);
  assign shortStep = {{SHORT_PAD{offset[BR_OFF_W-1]}}, offset[BR_OFF_W-1:0]};
  assign longStep  = {{LONG_PAD{offset[JMP_OFF_W-1]}}, offset};
  assign skipStep  = nextTwoWord ? PCW'(3) : PCW'(2);
  assign anyTaken  = strobe.useShort | strobe.useLong | strobe.usePtr | strobe.skipTaken;

  always_comb begin
    target = seqPc;
    if (strobe.useShort)       target = seqPc + shortStep;
    else if (strobe.useLong)   target = seqPc + longStep;
    else if (strobe.usePtr)    target = ptr;
    else if (strobe.skipTaken) target = pc + skipStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPc   <= '0;
      taken    <= 1'b0;
      illegal  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      outValid <= valid;
      if (valid) begin
        nextPc  <= target;
        taken   <= anyTaken;
        illegal <= strobe.badIo;
      end else begin
        taken   <= 1'b0;
        illegal <= 1'b0;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> outValid); // R2
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!taken && !illegal)); // R2
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    valid && !anyTaken |=> nextPc == PCW'($past(pc) + PCW'(1))); // R3
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    valid && strobe.usePtr |=> nextPc == $past(ptr)); // R6
  AST_SKIP_DIST: assert property (@(posedge clk) disable iff (!rstN)
    valid && strobe.skipTaken |=> (nextPc == PCW'($past(pc) + PCW'(2))) ||
                                  (nextPc == PCW'($past(pc) + PCW'(3)))); // R10
  AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !taken); // R9

endmodule

// File: rtl/pc_steer_top.sv
module pc_steer_top
  import pc_steer_pkg::*;
#(
  parameter int PCW          = 16,
  parameter int BR_OFF_W     = 7,
  parameter int JMP_OFF_W    = 12,
  parameter int IO_ADDR_W    = 6,
  parameter int IO_LOW_LIMIT = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 valid,
  input  logic [3:0]           opClass,
  input  logic [PCW-1:0]       pc,
  input  logic [JMP_OFF_W-1:0] offset,
  input  logic [7:0]           flags,
  input  logic [2:0]           flagSel,
  input  logic [PCW-1:0]       ptr,
  input  logic [7:0]           testByte,
  input  logic [7:0]           cmpByte,
  input  logic [2:0]           bitIdx,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  input  logic                 nextTwoWord,
  output logic [PCW-1:0]       nextPc,
  output logic                 taken,
  output logic                 illegal,
  output logic                 outValid
);

  steerStrobe_t strobe;

  pc_steer_ctrl #(
    .IO_ADDR_W   (IO_ADDR_W),
    .IO_LOW_LIMIT(IO_LOW_LIMIT)
  ) uCtrl (
    .opClass (opClass),
    .flags   (flags),
    .flagSel (flagSel),
    .testByte(testByte),
    .cmpByte (cmpByte),
    .bitIdx  (bitIdx),
    .ioAddr  (ioAddr),
    .strobe  (strobe)
  );

  pc_steer_path #(
    .PCW      (PCW),
    .BR_OFF_W (BR_OFF_W),
    .JMP_OFF_W(JMP_OFF_W)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .valid      (valid),
    .pc         (pc),
    .offset     (offset),
    .ptr        (ptr),
    .nextTwoWord(nextTwoWord),
    .strobe     (strobe),
    .nextPc     (nextPc),
    .taken      (taken),
    .illegal    (illegal),
    .outValid   (outValid)
  );

endmodule

// File: tb/tb_pc_steer_top.sv
module tb_pc_steer_top;

  localparam int PCW = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  opClass = '0;
  logic [15:0] pc = '0;
  logic [11:0] offset = '0;
  logic [7:0]  flags = '0;
  logic [2:0]  flagSel = '0;
  logic [15:0] ptr = '0;
  logic [7:0]  testByte = '0;
  logic [7:0]  cmpByte = '0;
  logic [2:0]  bitIdx = '0;
  logic [5:0]  ioAddr = '0;
  logic        nextTwoWord = 1'b0;
  logic [15:0] nextPc;
  logic        taken;
  logic        illegal;
  logic        outValid;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pc_steer_top dut (
    .clk(clk), .rstN(rstN), .valid(valid), .opClass(opClass), .pc(pc),
    .offset(offset), .flags(flags), .flagSel(flagSel), .ptr(ptr),
    .testByte(testByte), .cmpByte(cmpByte), .bitIdx(bitIdx), .ioAddr(ioAddr),
    .nextTwoWord(nextTwoWord), .nextPc(nextPc), .taken(taken),
    .illegal(illegal), .outValid(outValid)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected result built from the requirement text.
  task automatic expect_of(output int ePc, output int eTaken, output int eIll);
    int seq;
    int sOff;
    int lOff;
    int hit;
    seq = (pc + 1) % 65536;
    sOff = offset[6] ? int'(offset[6:0]) - 128 : int'(offset[6:0]);
    lOff = offset[11] ? int'(offset) - 4096 : int'(offset);
    hit = 0;
    eIll = 0;
    ePc = seq;
    case (opClass)
      4'd1: if (flags[flagSel]) begin hit = 1; ePc = (pc + 1 + sOff + 65536) % 65536; end
      4'd2: if (!flags[flagSel]) begin hit = 1; ePc = (pc + 1 + sOff + 65536) % 65536; end
      4'd3, 4'd4: begin hit = 1; ePc = (pc + 1 + lOff + 65536) % 65536; end
      4'd5, 4'd6: begin hit = 1; ePc = ptr; end
      4'd7: hit = (testByte == cmpByte) ? 2 : 0;
      4'd8: hit = testByte[bitIdx] ? 2 : 0;
      4'd9: hit = !testByte[bitIdx] ? 2 : 0;
      4'd10, 4'd11: begin
        if (ioAddr > 6'h1F) eIll = 1;
        else if (testByte[bitIdx] == (opClass == 4'd10)) hit = 2;
      end
      default: hit = 0;
    endcase
    if (hit == 2) ePc = (pc + (nextTwoWord ? 3 : 2)) % 65536;
    eTaken = (hit != 0) ? 1 : 0;
  endtask

  task automatic step(input string req);
    int ePc;
    int eTaken;
    int eIll;
    valid = 1'b1;
    expect_of(ePc, eTaken, eIll);
    @(negedge clk);
    check(req, int'(outValid), 1, "outValid");
    check(req, int'(nextPc), ePc, "nextPc");
    check(req, int'(taken), eTaken, "taken");
    check(req, int'(illegal), eIll, "illegal");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", int'(outValid), 0, "outValid");
    check("R1", int'(taken), 0, "taken");
    check("R1", int'(illegal), 0, "illegal");
    check("R1", int'(nextPc), 0, "nextPc");
    rstN = 1'b1;
    @(negedge clk);
    check("R2", int'(outValid), 0, "outValid idle");

    // R4 conditional branches: every flag, polarity, offset edge; upper offset bits ignored
    for (int op = 1; op <= 2; op++)
      for (int fs = 0; fs < 8; fs++)
        for (int fp = 0; fp < 10; fp++)
          for (int oi = 0; oi < 6; oi++) begin
            opClass = 4'(op);
            flagSel = 3'(fs);
            flags = (fp < 8) ? 8'(1 << fp) : ((fp == 8) ? 8'h00 : 8'hFF);
            case (oi)
              0: offset = 12'h000;
              1: offset = 12'h03F;
              2: offset = 12'h040;
              3: offset = 12'h07F;
              4: offset = 12'hF81;
              default: offset = 12'hA95;
            endcase
            pc = (fp[0]) ? 16'h0020 : 16'hFFF0;
            nextTwoWord = oi[0];
            step("R4");
          end

    // R5 relative jump and call, with wrap (R11)
    for (int op = 3; op <= 4; op++)
      for (int oi = 0; oi < 6; oi++)
        for (int pi = 0; pi < 3; pi++) begin
          opClass = 4'(op);
          case (oi)
            0: offset = 12'h000;
            1: offset = 12'h7FF;
            2: offset = 12'h800;
            3: offset = 12'hFFF;
            4: offset = 12'h001;
            default: offset = 12'h123;
          endcase
          pc = (pi == 0) ? 16'h0000 : ((pi == 1) ? 16'hFFFF : 16'h4000);
          nextTwoWord = pi[0];
          step("R5");
        end
    opClass = 4'd3; pc = 16'hFFFF; offset = 12'h001;
    step("R11");

    // R6 indirect transfers
    for (int op = 5; op <= 6; op++)
      for (int k = 0; k < 8; k++) begin
        opClass = 4'(op);
        ptr = 16'(k * 16'h2491 + 16'h0003);
        pc = 16'(k * 16'h1111);
        nextTwoWord = k[0];
        step("R6");
      end

    // R7 equality skip with both lengths (R10)
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int tw = 0; tw < 2; tw++) begin
          opClass = 4'd7;
          testByte = 8'(a * 17);
          cmpByte = 8'(b * 17);
          nextTwoWord = tw[0];
          pc = 16'h0100;
          step("R7");
        end

    // R8 register bit skips
    for (int op = 8; op <= 9; op++)
      for (int v = 0; v < 8; v++)
        for (int bi = 0; bi < 8; bi++)
          for (int tw = 0; tw < 2; tw++) begin
            opClass = 4'(op);
            testByte = 8'(v * 8'h25);
            bitIdx = 3'(bi);
            nextTwoWord = tw[0];
            pc = 16'hFFFE;
            step("R8");
          end

    // R9 I/O bit skips across the whole address space, both lengths (R10)
    for (int op = 10; op <= 11; op++)
      for (int ia = 0; ia < 64; ia++)
        for (int bi = 0; bi < 8; bi++)
          for (int tw = 0; tw < 2; tw++) begin
            opClass = 4'(op);
            ioAddr = 6'(ia);
            bitIdx = 3'(bi);
            testByte = 8'h5A ^ 8'(ia);
            nextTwoWord = tw[0];
            pc = 16'(ia * 16'h0101);
            step("R9");
          end

    // R3 / R10 sequential classes ignore the length flag
    for (int op = 0; op < 16; op++) begin
      if (op == 0 || op >= 12) begin
        for (int tw = 0; tw < 2; tw++) begin
          opClass = 4'(op);
          nextTwoWord = tw[0];
          flags = 8'hFF;
          pc = 16'hFFFF;
          step("R3");
        end
      end
    end

    // R2 idle after requests
    valid = 1'b0;
    @(negedge clk);
    check("R2", int'(outValid), 0, "outValid after idle");
    check("R2", int'(taken), 0, "taken after idle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule